// File: doc/BRIEF.md
# Buffer Descriptor List Sequencer

This block steps through a list of buffer descriptors for a single audio stream. Each descriptor is read from memory as four 32-bit words. The descriptor for entry `n` sits at `list_base + 16*n`. After the fetch the sequencer holds the buffer's start address, its byte length and its completion-interrupt flag, and it sets its offset within that buffer to zero. The stream engine then asks for a number of bytes with `xfer_req`. The sequencer grants at most the bytes left in the buffer and moves that amount as a run of data requests on the memory port. No request is larger than the FIFO allowance.

When an entry has been used up, the sequencer does three things. It pulses `entry_done`, it raises `ioc_irq` if the entry carries the completion flag, and it fetches the next entry. After the last valid index it returns to entry 0. An entry of zero length completes as soon as it is loaded, without any data request. An error response from memory stops the current transfer, and the bytes already moved are kept.

Memory port: `mem_req` stays high with a stable address and size until the memory answers with a one-cycle `mem_ack` or `mem_err` in a cycle where `mem_req` is high. The request completes on the next rising edge. `mem_is_data` tells descriptor reads (0) from data chunks (1).

Top module: `bdl_dma_seq`

## Requirements
- R1: After reset, `mem_req`, `ready`, `xfer_done`, `entry_done`, `ioc_irq` and `dma_err` are low, and `cur_idx` and `cur_off` are zero.
- R2: A `start` pulse while `list_base` is zero issues no memory request and pulses `dma_err` in the next cycle.
- R3: A fetch of entry n issues four reads with `mem_is_data`=0 and size 4, at `list_base + 16*n + 4*w` for w = 0..3 in order. The word meanings are: w0 holds the buffer address bits 31:0, w1 holds address bits 63:32, w2 holds the length in bytes, and w3 holds the flags.
- R4: Once a fetch completes, `cur_off` is 0 and `cur_idx` equals the fetched index when `ready` rises.
- R5: An accepted `xfer_req` moves min(`xfer_bytes`, length − offset) bytes and reports that count on `xfer_moved` with a `xfer_done` pulse.
- R6: Each data request has size min(bytes still to move, F), where F is `fifo_bytes` rounded down to a whole frame. Its address is the buffer address plus the current offset, so successive chunks are contiguous.
- R7: An entry is complete when its length is 0 or its offset is at least its length. A zero-length entry completes without any data request. `entry_done` is high for one cycle, exactly 3 cycles after the cycle in which the completing response (last data chunk, or flags word of a zero-length entry) is given.
- R8: `ioc_irq` is high in the same cycle as `entry_done` exactly when bit 0 of the completed entry's flags word is 1. `done_idx` names the completed entry.
- R9: The entry after index `last_idx` is index 0. Otherwise the next entry is the current index plus one.
- R10: An error response on a data chunk ends the transfer. `xfer_moved` reports the bytes acknowledged before the error, `dma_err` pulses together with `xfer_done`, and the offset advances by only those bytes.
- R11: While `mem_req` is high and no response has been given, the request, address, size and kind hold steady.
- R12: Data chunk sizes are nonzero multiples of `FRAME_BYTES` and do not exceed `fifo_bytes`.
- R13: A `xfer_req` with zero bytes gives a `xfer_done` pulse with `xfer_moved` = 0 and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| list_base | input | 64 | Byte address of descriptor entry 0 |
| last_idx | input | IDX_W | Highest valid entry index |
| fifo_bytes | input | FIFO_W | FIFO allowance per chunk in bytes |
| start | input | 1 | Begin walking the list at entry 0 (accepted when idle) |
| xfer_req | input | 1 | Request a transfer (accepted when `ready`) |
| xfer_bytes | input | 32 | Bytes wanted by the request |
| mem_req | output | 1 | Memory request valid |
| mem_is_data | output | 1 | 1 = data chunk, 0 = descriptor word read |
| mem_addr | output | 64 | Request byte address |
| mem_size | output | 32 | Request size in bytes |
| mem_ack | input | 1 | Successful response |
| mem_err | input | 1 | Error response |
| mem_rdata | input | 32 | Read data for descriptor words |
| ready | output | 1 | Entry loaded and not complete, request can be taken |
| xfer_done | output | 1 | Transfer finished pulse |
| xfer_moved | output | 32 | Bytes moved by the finished transfer |
| entry_done | output | 1 | Entry completed pulse |
| ioc_irq | output | 1 | Completion interrupt request pulse |
| done_idx | output | IDX_W | Index of the entry that completed |
| cur_idx | output | IDX_W | Index of the entry currently held |
| cur_off | output | 32 | Byte offset within the current buffer |
| dma_err | output | 1 | Error pulse (zero list base or memory error) |

## Verification
The assertions take for granted that `list_base`, `last_idx` and `fifo_bytes` stay constant while the list is being walked. They also assume that descriptor lengths and the FIFO allowance are whole multiples of the frame size, and that the memory answers only while a request is pending. The stimulus sets the configuration only while the block is idle, and it uses lengths and request sizes that are multiples of four bytes. Its behavioural memory answers with 0, 1 or 2 wait cycles and only while `mem_req` is high. The zero-base case is exercised before any valid base is applied, so the base-zero property sees no request.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
  localparam int ADDR_W     = 64;
  localparam int LEN_W      = 32;
  localparam int WORD_BYTES = 4;
  localparam int DESC_WORDS = 4;
  localparam int DESC_SHIFT = 4;
  localparam int WSEL_W     = $clog2(DESC_WORDS);

  typedef struct packed {
    logic [ADDR_W-1:0] buf_addr;
    logic [LEN_W-1:0]  len;
    logic              ioc;
  } bdl_desc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_READY = 2'd2,
    ST_XFER  = 2'd3
  } seq_state_e;

  // Byte address of one descriptor word.
  function automatic logic [ADDR_W-1:0] desc_word_addr(
    input logic [ADDR_W-1:0] base,
    input logic [LEN_W-1:0]  idx,
    input logic [WSEL_W-1:0] w
  );
    logic [ADDR_W-1:0] ent;
    logic [ADDR_W-1:0] wof;
    ent = {{(ADDR_W-LEN_W){1'b0}}, idx} << DESC_SHIFT;
    wof = ADDR_W'(w) * ADDR_W'(WORD_BYTES);
    return base + ent + wof;
  endfunction

  // True once the buffer is used up or was empty.
  function automatic logic entry_is_done(
    input logic [LEN_W-1:0] len,
    input logic [LEN_W-1:0] off
  );
    return (len == '0) || (off >= len);
  endfunction

  // Bytes granted to one request: the request capped by what is left.
  function automatic logic [LEN_W-1:0] clamp_bytes(
    input logic [LEN_W-1:0] want,
    input logic [LEN_W-1:0] len,
    input logic [LEN_W-1:0] off
  );
    logic [LEN_W-1:0] rem;
    if (off >= len) return '0;
    rem = len - off;
    return (want < rem) ? want : rem;
  endfunction

  // One chunk: what is left, capped by the FIFO allowance in whole frames.
  function automatic logic [LEN_W-1:0] chunk_bytes(
    input logic [LEN_W-1:0] left,
    input logic [LEN_W-1:0] fifo,
    input logic [LEN_W-1:0] frame
  );
    logic [LEN_W-1:0] cap;
    cap = fifo - (fifo % frame);
    return (left < cap) ? left : cap;
  endfunction
endpackage

// File: rtl/bdl_desc_fetch.sv
module bdl_desc_fetch
  import bdl_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              ack,
  input  logic              err,
  input  logic [31:0]       rdata,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic              loaded,
  output bdl_desc_t         desc,
  output logic              fail
);
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(DESC_WORDS - 1);

  logic              active_q;
  logic [WSEL_W-1:0] word_q;
  logic              word_last;

  assign req       = active_q;
  assign addr      = desc_word_addr(base, LEN_W'(idx), word_q);
  assign word_last = (word_q == LAST_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      word_q   <= '0;
      loaded   <= 1'b0;
      fail     <= 1'b0;
      desc     <= '0;
    end else begin
      loaded <= 1'b0;
      fail   <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        word_q   <= '0;
      end else if (active_q && err) begin
        active_q <= 1'b0;
        fail     <= 1'b1;
      end else if (active_q && ack) begin
        case (word_q)
          2'd0:    desc.buf_addr[31:0]  <= rdata;
          2'd1:    desc.buf_addr[63:32] <= rdata;
          2'd2:    desc.len             <= rdata;
          default: desc.ioc             <= rdata[0];
        endcase
        word_q <= word_q + 1'b1;
        if (word_last) begin
          active_q <= 1'b0;
          loaded   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bdl_chunk_mover.sv
module bdl_chunk_mover
  import bdl_pkg::*;
#(
  parameter int FIFO_W      = 16,
  parameter int FRAME_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_left,
  input  logic [FIFO_W-1:0] fifo_bytes,
  input  logic              ack,
  input  logic              err,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  size,
  output logic              done,
  output logic [LEN_W-1:0]  moved,
  output logic              fail
);
  localparam logic [LEN_W-1:0] FRAME = LEN_W'(FRAME_BYTES);

  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              chunk_last;

  assign req        = active_q;
  assign addr       = addr_q;
  assign size       = chunk_bytes(left_q, LEN_W'(fifo_bytes), FRAME);
  assign chunk_last = (left_q == size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
      moved    <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        addr_q   <= start_addr;
        left_q   <= start_left;
        moved    <= '0;
      end else if (active_q && err) begin
        active_q <= 1'b0;
        done     <= 1'b1;
        fail     <= 1'b1;
      end else if (active_q && ack) begin
        addr_q <= addr_q + ADDR_W'(size);
        left_q <= left_q - size;
        moved  <= moved + size;
        if (chunk_last) begin
          active_q <= 1'b0;
          done     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bdl_port_mux.sv
module bdl_port_mux
  import bdl_pkg::*;
(
  input  logic              sel_data,
  input  logic              f_req,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              m_req,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [LEN_W-1:0]  m_size,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              mem_req,
  output logic              mem_is_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_size,
  output logic              f_ack,
  output logic              f_err,
  output logic              m_ack,
  output logic              m_err
);
  always_comb begin
    mem_is_data = sel_data;
    if (sel_data) begin
      mem_req  = m_req;
      mem_addr = m_addr;
      mem_size = m_size;
    end else begin
      mem_req  = f_req;
      mem_addr = f_addr;
      mem_size = LEN_W'(WORD_BYTES);
    end
    f_ack = !sel_data && mem_ack;
    f_err = !sel_data && mem_err;
    m_ack = sel_data && mem_ack;
    m_err = sel_data && mem_err;
  end
endmodule

// File: rtl/bdl_dma_seq.sv
module bdl_dma_seq
  import bdl_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int FIFO_W      = 16,
  parameter int FRAME_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] list_base,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [FIFO_W-1:0] fifo_bytes,
  input  logic              start,
  input  logic              xfer_req,
  input  logic [LEN_W-1:0]  xfer_bytes,
  output logic              mem_req,
  output logic              mem_is_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_size,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              ready,
  output logic              xfer_done,
  output logic [LEN_W-1:0]  xfer_moved,
  output logic              entry_done,
  output logic              ioc_irq,
  output logic [IDX_W-1:0]  done_idx,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [LEN_W-1:0]  cur_off,
  output logic              dma_err
);
  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  off_q;
  bdl_desc_t         desc_q;
  logic              fetch_go_q, mv_go_q;
  logic [ADDR_W-1:0] mv_addr_q;
  logic [LEN_W-1:0]  mv_left_q;
  logic              zero_done_q, done_q, irq_q, base_err_q;
  logic [IDX_W-1:0]  done_idx_q;

  // Sub-block wires
  logic              f_req, f_ack, f_err, f_loaded, f_fail;
  logic [ADDR_W-1:0] f_addr;
  bdl_desc_t         f_desc;
  logic              m_req, m_ack, m_err, m_done, m_fail;
  logic [ADDR_W-1:0] m_addr;
  logic [LEN_W-1:0]  m_size, m_moved;

  // Named events and arithmetic
  logic              ent_complete;
  logic [LEN_W-1:0]  grant;
  logic [IDX_W-1:0]  next_idx;
  logic              ev_desc_load, ev_entry_close, ev_accept;
  logic              base_zero;

  assign ent_complete   = entry_is_done(desc_q.len, off_q);
  assign grant          = clamp_bytes(xfer_bytes, desc_q.len, off_q);
  assign next_idx       = (idx_q == last_idx) ? '0 : idx_q + 1'b1;
  assign base_zero      = (list_base == '0);
  assign ev_desc_load   = (state_q == ST_FETCH) && f_loaded;
  assign ev_entry_close = (state_q == ST_READY) && ent_complete;
  assign ev_accept      = (state_q == ST_READY) && !ent_complete && xfer_req;

  bdl_desc_fetch #(.IDX_W(IDX_W)) u_fetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (fetch_go_q),
    .base   (list_base),
    .idx    (idx_q),
    .ack    (f_ack),
    .err    (f_err),
    .rdata  (mem_rdata),
    .req    (f_req),
    .addr   (f_addr),
    .loaded (f_loaded),
    .desc   (f_desc),
    .fail   (f_fail)
  );

  bdl_chunk_mover #(.FIFO_W(FIFO_W), .FRAME_BYTES(FRAME_BYTES)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (mv_go_q),
    .start_addr (mv_addr_q),
    .start_left (mv_left_q),
    .fifo_bytes (fifo_bytes),
    .ack        (m_ack),
    .err        (m_err),
    .req        (m_req),
    .addr       (m_addr),
    .size       (m_size),
    .done       (m_done),
    .moved      (m_moved),
    .fail       (m_fail)
  );

  bdl_port_mux u_mux (
    .sel_data    (state_q != ST_FETCH),
    .f_req       (f_req),
    .f_addr      (f_addr),
    .m_req       (m_req),
    .m_addr      (m_addr),
    .m_size      (m_size),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .mem_req     (mem_req),
    .mem_is_data (mem_is_data),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .f_ack       (f_ack),
    .f_err       (f_err),
    .m_ack       (m_ack),
    .m_err       (m_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      off_q       <= '0;
      desc_q      <= '0;
      fetch_go_q  <= 1'b0;
      mv_go_q     <= 1'b0;
      mv_addr_q   <= '0;
      mv_left_q   <= '0;
      zero_done_q <= 1'b0;
      done_q      <= 1'b0;
      irq_q       <= 1'b0;
      base_err_q  <= 1'b0;
      done_idx_q  <= '0;
    end else begin
      fetch_go_q  <= 1'b0;
      mv_go_q     <= 1'b0;
      zero_done_q <= 1'b0;
      done_q      <= 1'b0;
      irq_q       <= 1'b0;
      base_err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (base_zero) begin
              base_err_q <= 1'b1;
            end else begin
              idx_q      <= '0;
              fetch_go_q <= 1'b1;
              state_q    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (ev_desc_load) begin
            desc_q  <= f_desc;
            off_q   <= '0;
            state_q <= ST_READY;
          end else if (f_fail) begin
            state_q <= ST_IDLE;
          end
        end
        ST_READY: begin
          if (ev_entry_close) begin
            done_q     <= 1'b1;
            irq_q      <= desc_q.ioc;
            done_idx_q <= idx_q;
            idx_q      <= next_idx;
            if (base_zero) begin
              base_err_q <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              fetch_go_q <= 1'b1;
              state_q    <= ST_FETCH;
            end
          end else if (ev_accept) begin
            if (grant == '0) begin
              zero_done_q <= 1'b1;
            end else begin
              mv_go_q   <= 1'b1;
              mv_addr_q <= desc_q.buf_addr + ADDR_W'(off_q);
              mv_left_q <= grant;
              state_q   <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (m_done) begin
            off_q   <= off_q + m_moved;
            state_q <= ST_READY;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready      = (state_q == ST_READY) && !ent_complete;
  assign xfer_done  = m_done || zero_done_q;
  assign xfer_moved = zero_done_q ? '0 : m_moved;
  assign entry_done = done_q;
  assign ioc_irq    = irq_q;
  assign done_idx   = done_idx_q;
  assign cur_idx    = idx_q;
  assign cur_off    = off_q;
  assign dma_err    = base_err_q || f_fail || m_fail;
endmodule

// File: rtl/bdl_dma_seq_chk.sv
module bdl_dma_seq_chk
  import bdl_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int FIFO_W      = 16,
  parameter int FRAME_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] list_base,
  input logic [IDX_W-1:0]  last_idx,
  input logic [FIFO_W-1:0] fifo_bytes,
  input logic              mem_req,
  input logic              mem_is_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LEN_W-1:0]  mem_size,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              ready,
  input logic              entry_done,
  input logic              ioc_irq,
  input logic [IDX_W-1:0]  done_idx,
  input logic [IDX_W-1:0]  cur_idx
);
  // R11: pending request holds steady
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_is_data)));

  // R12: data chunk bounded by the FIFO allowance and nonzero
  a_r12_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_is_data) |-> (mem_size != '0 && mem_size <= LEN_W'(fifo_bytes)));

  // R12: whole frames per chunk
  a_r12_frame_mult: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_is_data) |-> ((mem_size % LEN_W'(FRAME_BYTES)) == '0));

  // R3: descriptor reads are single words
  a_r3_desc_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_is_data) |-> (mem_size == LEN_W'(WORD_BYTES)));

  // R2: no memory traffic with a zero list base
  a_r2_zero_base_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (list_base == '0) |-> !mem_req);

  // R8: interrupt only together with a completion
  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_irq |-> entry_done);

  // R9: wrap after the last valid entry
  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_done && done_idx == last_idx) |-> (cur_idx == '0));

  // R7: a completion is never reported while a request is on the port
  a_r7_done_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> !mem_req);

  // R5: ready means the port is quiet
  a_r5_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req);
endmodule

bind bdl_dma_seq bdl_dma_seq_chk #(
  .IDX_W(IDX_W), .FIFO_W(FIFO_W), .FRAME_BYTES(FRAME_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .list_base   (list_base),
  .last_idx    (last_idx),
  .fifo_bytes  (fifo_bytes),
  .mem_req     (mem_req),
  .mem_is_data (mem_is_data),
  .mem_addr    (mem_addr),
  .mem_size    (mem_size),
  .mem_ack     (mem_ack),
  .mem_err     (mem_err),
  .ready       (ready),
  .entry_done  (entry_done),
  .ioc_irq     (ioc_irq),
  .done_idx    (done_idx),
  .cur_idx     (cur_idx)
);

// File: tb/bdl_dma_seq_tb.sv
module bdl_dma_seq_tb;
  localparam int IDX_W = 8;
  localparam int FIFO_W = 16;
  localparam int NENT = 4;
  localparam int FIFO = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] list_base = 0;
  logic [IDX_W-1:0] last_idx = IDX_W'(NENT - 1);
  logic [FIFO_W-1:0] fifo_bytes = FIFO_W'(FIFO);
  logic        start = 0, xfer_req = 0;
  logic [31:0] xfer_bytes = 0;
  logic        mem_req, mem_is_data;
  logic [63:0] mem_addr;
  logic [31:0] mem_size;
  logic        mem_ack = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0;
  logic        ready, xfer_done, entry_done, ioc_irq, dma_err;
  logic [31:0] xfer_moved, cur_off;
  logic [IDX_W-1:0] done_idx, cur_idx;

  bdl_dma_seq #(.IDX_W(IDX_W), .FIFO_W(FIFO_W), .FRAME_BYTES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .list_base(list_base), .last_idx(last_idx),
    .fifo_bytes(fifo_bytes), .start(start), .xfer_req(xfer_req),
    .xfer_bytes(xfer_bytes), .mem_req(mem_req), .mem_is_data(mem_is_data),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .ready(ready),
    .xfer_done(xfer_done), .xfer_moved(xfer_moved), .entry_done(entry_done),
    .ioc_irq(ioc_irq), .done_idx(done_idx), .cur_idx(cur_idx),
    .cur_off(cur_off), .dma_err(dma_err)
  );

  always #5 clk = ~clk;

  typedef struct {
    longint unsigned addr;
    int unsigned     size;
    bit              data;
    bit              completes;
    bit              irq;
    int              idx;
    bit              err;
  } exp_t;

  exp_t q[$];
  longint unsigned d_addr[NENT];
  int unsigned d_len[NENT];
  int unsigned d_flags[NENT];
  longint unsigned base_v = 64'h1000;
  int compared = 0, mismatched = 0;
  int cyc = 0;
  int lat = 0;
  int wait_cnt = 0;
  int sched_cyc = -1;
  bit sched_irq = 0;
  int sched_idx = 0;
  int dones_seen = 0, dones_exp = 0;
  int m_cur = 0;
  int unsigned m_off = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nxt(input int i);
    return (i == NENT - 1) ? 0 : i + 1;
  endfunction

  // R3/R7: queue the four descriptor reads, walking over empty entries
  function automatic void expect_fetch(input int first);
    int i = first;
    bit more = 1;
    while (more) begin
      for (int w = 0; w < 4; w++) begin
        exp_t it;
        it.addr = base_v + longint'(i) * 16 + longint'(w) * 4;
        it.size = 4; it.data = 0; it.err = 0; it.idx = i;
        it.completes = (w == 3) && (d_len[i] == 0);
        it.irq = d_flags[i][0];
        q.push_back(it);
      end
      if (d_len[i] == 0) begin
        dones_exp++;
        i = nxt(i);
      end else begin
        more = 0;
      end
    end
    m_cur = i;
    m_off = 0;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural memory and per-clock reference comparison
  always @(negedge clk) begin
    mem_ack = 0;
    mem_err = 0;
    if (rst_n) begin
      if (mem_req) begin
        if (wait_cnt < lat) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          if (q.size() == 0) begin
            chk(0, "R3", "unexpected request addr", mem_addr, 0);
            mem_ack = 1;
          end else begin
            exp_t it;
            longint unsigned rel;
            int ei, ew;
            it = q.pop_front();
            chk(mem_is_data == it.data, it.data ? "R6" : "R3", "request kind", mem_is_data, it.data);
            chk(mem_addr == it.addr, it.data ? "R6" : "R3", "request address", mem_addr, it.addr);
            chk(mem_size == it.size, it.data ? "R6" : "R3", "request size", mem_size, it.size);
            if (!it.data) begin
              rel = mem_addr - base_v;
              ei = int'(rel >> 4) % NENT;
              ew = int'((rel >> 2) & 3);
              case (ew)
                0: mem_rdata = d_addr[ei][31:0];
                1: mem_rdata = d_addr[ei][63:32];
                2: mem_rdata = d_len[ei];
                default: mem_rdata = d_flags[ei];
              endcase
            end
            if (it.err) mem_err = 1; else mem_ack = 1;
            if (it.completes) begin
              sched_cyc = cyc + 3;
              sched_irq = it.irq;
              sched_idx = it.idx;
            end
          end
        end
      end else begin
        wait_cnt = 0;
      end
      // R7/R8: completion and interrupt timing, every cycle
      chk(entry_done == (cyc == sched_cyc), "R7", "entry_done timing", entry_done, cyc == sched_cyc);
      chk(ioc_irq == ((cyc == sched_cyc) && sched_irq), "R8", "ioc_irq", ioc_irq,
          (cyc == sched_cyc) && sched_irq);
      if (entry_done) begin
        dones_seen++;
        chk(done_idx == IDX_W'(sched_idx), "R8", "done_idx", done_idx, sched_idx);
      end
    end
  end

  // One transfer: R4 at ready, R5/R6 chunking, R10 error injection, R13 zero request
  task automatic do_xfer(input int unsigned bytes, input int err_chunk, input string req);
    int unsigned len, rem, left, moved, c;
    longint unsigned a;
    bit err_hit = 0;
    int k = 0;
    do @(negedge clk); while (!ready);
    chk(cur_idx == IDX_W'(m_cur), "R4 R9", "cur_idx at ready", cur_idx, m_cur);
    chk(cur_off == m_off, "R4", "cur_off at ready", cur_off, m_off);
    len = d_len[m_cur];
    rem = (m_off >= len) ? 0 : len - m_off;
    left = (bytes < rem) ? bytes : rem;
    moved = 0;
    a = d_addr[m_cur] + m_off;
    while (left > 0) begin
      exp_t it;
      c = (left < FIFO) ? left : FIFO;
      it.addr = a; it.size = c; it.data = 1; it.idx = m_cur;
      it.irq = d_flags[m_cur][0];
      it.err = (k == err_chunk);
      it.completes = !it.err && (left == c) && (m_off + moved + c >= len);
      q.push_back(it);
      if (it.err) begin err_hit = 1; break; end
      a += c; moved += c; left -= c; k++;
    end
    if (!err_hit && moved > 0 && m_off + moved >= len) begin
      dones_exp++;
      expect_fetch(nxt(m_cur));
    end else begin
      m_off += moved;
    end
    xfer_bytes = bytes;
    xfer_req = 1;
    @(negedge clk);
    xfer_req = 0;
    while (!xfer_done) @(negedge clk);
    chk(xfer_moved == moved, req, "bytes moved", xfer_moved, moved);
    chk(dma_err == err_hit, req, "dma_err with done", dma_err, err_hit);
  endtask

  initial begin
    d_addr[0] = 64'h0000_0001_0000_2000; d_len[0] = 48; d_flags[0] = 32'h1;
    d_addr[1] = 64'h3000;                d_len[1] = 0;  d_flags[1] = 32'h1;
    d_addr[2] = 64'h4000;                d_len[2] = 24; d_flags[2] = 32'h0;
    d_addr[3] = 64'h5000;                d_len[3] = 16; d_flags[3] = 32'hFFFF_FFF1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!mem_req && !ready && !xfer_done, "R1", "idle port/ready/done", {mem_req, ready, xfer_done}, 0);
    chk(!entry_done && !ioc_irq && !dma_err, "R1", "idle pulses", {entry_done, ioc_irq, dma_err}, 0);
    chk(cur_idx == 0 && cur_off == 0, "R1", "index/offset", {cur_idx, cur_off}, 0);

    // R2: zero base refused
    list_base = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(dma_err == 1, "R2", "dma_err after zero-base start", dma_err, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!mem_req, "R2", "no request on zero base", mem_req, 0);
    end

    // Walk the list
    list_base = base_v;
    expect_fetch(0);
    start = 1;
    @(negedge clk);
    start = 0;
    lat = 0;
    do_xfer(20, -1, "R5");   // chunks 16 + 4
    do_xfer(0, -1, "R13");   // nothing moves
    lat = 1;
    do_xfer(100, -1, "R5");  // capped to 28, entry completes, empty entry follows
    do_xfer(24, 1, "R10");   // second chunk errors
    lat = 2;
    do_xfer(24, -1, "R10");  // resumes at offset 16
    lat = 0;
    do_xfer(16, -1, "R8");   // last entry, wraps to 0
    do_xfer(8, -1, "R9");
    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R6", "outstanding expected requests", q.size(), 0);
    chk(dones_seen == dones_exp, "R7", "completions seen", dones_seen, dones_exp);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual %0d expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule